// File: doc/BRIEF.md
# Lane-Partitioned Saturating Vector Adder

This block adds or subtracts two 64-bit operands treated as a vector of independent integer elements. A two-bit width select chooses eight 8-bit, four 16-bit or two 32-bit elements. The 64-bit carry chain is built from byte slices, and the carry is cut at every element boundary. Each element can be treated as signed or unsigned. When clamping is enabled, an element whose true result does not fit is forced to the nearest representable limit instead of wrapping. An overflow flag is produced for each element and copied onto every byte the element covers.

Operands and controls enter together on a valid/ready stream. The sum is computed combinationally and captured in a single output register, which is offered on a second valid/ready stream. A new beat is accepted when the register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the register holds its contents, `in_ready` is low and the upstream source must keep its beat. The result of an accepted beat appears one clock after acceptance. The byte count is a parameter and must be a multiple of four.

Top module: `simd_sat_adder`

## Requirements
- R1: `in_mode` selects the element width: 2'b00 gives eight 8-bit elements, 2'b01 gives four 16-bit elements, 2'b10 gives two 32-bit elements, and 2'b11 behaves exactly like 2'b10. Element k occupies bits [k*w+w-1 : k*w].
- R2: No carry or borrow passes from one element into the next, so each element's result depends only on that element's operand bits.
- R3: With `in_sub`=1 each element computes a − b as a + ~b + 1. With `in_sub`=0 each element computes a + b.
- R4: With `in_signed`=1 an element overflows exactly when its true two's-complement result lies outside [−2^(w−1), 2^(w−1)−1]. For addition this is when the operand signs match and the result sign differs. For subtraction this is when the operand signs differ and the result sign differs from a.
- R5: With `in_signed`=0 an element overflows on a carry out of an addition, or on a borrow (a < b) in a subtraction.
- R6: `out_ovf` bit i belongs to result byte i (bits [8i+7:8i]). Every byte of an element carries that element's overflow flag.
- R7: With `in_sat`=1 and `in_signed`=1, an overflowing element outputs its maximum (for example 0x7F) when the true result is positive, and its minimum (for example 0x80) when it is negative.
- R8: With `in_sat`=1 and `in_signed`=0, an overflowing addition outputs all ones and an overflowing subtraction outputs zero.
- R9: With `in_sat`=0 every element wraps modulo 2^w, and the overflow flags are still reported.
- R10: A beat is accepted on a rising edge with `in_valid` and `in_ready` both high, where `in_ready = !out_valid || out_ready`. Its result is on `out_data`/`out_ovf` with `out_valid` high from the next cycle on. Outputs stay unchanged while `out_valid` is high and `out_ready` is low.
- R11: While `rst_n` is low, `out_valid`, `out_data` and `out_ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept a beat |
| in_a | input | 64 | First operand vector |
| in_b | input | 64 | Second operand vector |
| in_mode | input | 2 | Element width select (R1) |
| in_sub | input | 1 | 1 = subtract, 0 = add |
| in_signed | input | 1 | 1 = two's-complement elements |
| in_sat | input | 1 | 1 = clamp on overflow |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Result vector |
| out_ovf | output | 8 | Per-byte overflow flag |

## Verification
A carry cut missing at one boundary corrupts the low bit of the byte just above that boundary. It shows on `out_data` in the cycle after the beat is accepted, and only in the narrower modes. A flag taken from the wrong byte or copied to the wrong bytes shows as `out_ovf` bits that disagree within one element, again one cycle after acceptance. A clamp driven by the wrong sign shows as 0x7F/0x80 or 0xFF/0x00 swapped. A faulty hold in the output register shows as a changed result in the very next stalled cycle, or as a beat that is dropped or repeated.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    LM_B8   = 2'd0,
    LM_B16  = 2'd1,
    LM_B32  = 2'd2,
    LM_B32X = 2'd3
  } lane_mode_t;

  // bytes covered by one element in a given mode
  function automatic int unsigned lane_bytes(input lane_mode_t m);
    case (m)
      LM_B8:   return 1;
      LM_B16:  return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/simd_lane_ctrl.sv
module simd_lane_ctrl
  import simd_pkg::*;
#(
  parameter int NBYTES = 8
) (
  input  lane_mode_t        mode_i,
  output logic [NBYTES-1:0] first_o,
  output logic [NBYTES-1:0] last_o
);

  generate
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      localparam logic FIRST16 = 1'((g % 2) == 0);
      localparam logic LAST16  = 1'((g % 2) == 1);
      localparam logic FIRST32 = 1'((g % 4) == 0);
      localparam logic LAST32  = 1'((g % 4) == 3);

      assign first_o[g] = (lane_bytes(mode_i) == 1) ? 1'b1 :
                          (lane_bytes(mode_i) == 2) ? FIRST16 : FIRST32;
      assign last_o[g]  = (lane_bytes(mode_i) == 1) ? 1'b1 :
                          (lane_bytes(mode_i) == 2) ? LAST16 : LAST32;
    end
  endgenerate

endmodule

// File: rtl/simd_byte_slice.sv
module simd_byte_slice #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              carry_i,
  output logic [BYTE_W-1:0] sum_o,
  output logic              carry_o,
  output logic              msb_carry_o
);

  localparam int LOW_W = BYTE_W - 1;

  logic [BYTE_W-1:0] b_eff;
  logic [LOW_W:0]    low;
  logic [1:0]        top;

  // carry into the sign bit is kept apart for signed overflow detection
  always_comb begin
    b_eff       = sub_i ? ~b_i : b_i;
    low         = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]}
                + {{LOW_W{1'b0}}, carry_i};
    top         = {1'b0, a_i[BYTE_W-1]} + {1'b0, b_eff[BYTE_W-1]}
                + {1'b0, low[LOW_W]};
    sum_o       = {top[0], low[LOW_W-1:0]};
    carry_o     = top[1];
    msb_carry_o = low[LOW_W];
  end

endmodule

// File: rtl/simd_sat_clamp.sv
module simd_sat_clamp #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] wrap_i,
  input  logic              ovf_i,
  input  logic              sat_i,
  input  logic              signed_i,
  input  logic              sub_i,
  input  logic              a_neg_i,
  input  logic              is_top_i,
  output logic [BYTE_W-1:0] byte_o
);

  localparam logic [BYTE_W-1:0] ONES  = {BYTE_W{1'b1}};
  localparam logic [BYTE_W-1:0] ZEROS = {BYTE_W{1'b0}};
  localparam logic [BYTE_W-1:0] SMAX  = {1'b0, {(BYTE_W-1){1'b1}}};
  localparam logic [BYTE_W-1:0] SMIN  = {1'b1, {(BYTE_W-1){1'b0}}};

  // signed overflow always lands on the side of operand a's sign
  always_comb begin
    if (!sat_i || !ovf_i) begin
      byte_o = wrap_i;
    end else if (signed_i) begin
      if (is_top_i) byte_o = a_neg_i ? SMIN  : SMAX;
      else          byte_o = a_neg_i ? ZEROS : ONES;
    end else begin
      byte_o = sub_i ? ZEROS : ONES;
    end
  end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_pkg::*;
#(
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NBYTES*BYTE_W-1:0] in_a,
  input  logic [NBYTES*BYTE_W-1:0] in_b,
  input  logic [1:0]               in_mode,
  input  logic                     in_sub,
  input  logic                     in_signed,
  input  logic                     in_sat,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NBYTES*BYTE_W-1:0] out_data,
  output logic [NBYTES-1:0]        out_ovf
);

  localparam int DATA_W = NBYTES * BYTE_W;

  lane_mode_t mode;
  assign mode = lane_mode_t'(in_mode);

  logic [NBYTES-1:0] first_b, last_b;
  logic [NBYTES-1:0] carry_in, carry_out, msb_carry, raw_ovf;
  logic [NBYTES-1:0] lane_ovf, lane_neg;
  logic [DATA_W-1:0] wrap_sum, clamp_sum;
  logic              in_fire;

  simd_lane_ctrl #(.NBYTES(NBYTES)) u_lane_ctrl (
    .mode_i  (mode),
    .first_o (first_b),
    .last_o  (last_b)
  );

  generate
    for (genvar g = 0; g < NBYTES; g++) begin : g_slice
      // carry chain cut: the first byte of an element takes the sub bit
      if (g == 0) begin : g_first
        assign carry_in[g] = in_sub;
      end else begin : g_rest
        assign carry_in[g] = first_b[g] ? in_sub : carry_out[g-1];
      end

      simd_byte_slice #(.BYTE_W(BYTE_W)) u_slice (
        .a_i         (in_a[g*BYTE_W +: BYTE_W]),
        .b_i         (in_b[g*BYTE_W +: BYTE_W]),
        .sub_i       (in_sub),
        .carry_i     (carry_in[g]),
        .sum_o       (wrap_sum[g*BYTE_W +: BYTE_W]),
        .carry_o     (carry_out[g]),
        .msb_carry_o (msb_carry[g])
      );

      assign raw_ovf[g] = in_signed ? (carry_out[g] ^ msb_carry[g])
                                    : (in_sub ? ~carry_out[g] : carry_out[g]);
    end
  endgenerate

  // spread each element's top-byte flag and operand-a sign down its bytes
  always_comb begin
    lane_ovf[NBYTES-1] = raw_ovf[NBYTES-1];
    lane_neg[NBYTES-1] = in_a[DATA_W-1];
    for (int i = NBYTES - 2; i >= 0; i--) begin
      lane_ovf[i] = last_b[i] ? raw_ovf[i]              : lane_ovf[i+1];
      lane_neg[i] = last_b[i] ? in_a[i*BYTE_W+BYTE_W-1] : lane_neg[i+1];
    end
  end

  generate
    for (genvar g = 0; g < NBYTES; g++) begin : g_clamp
      simd_sat_clamp #(.BYTE_W(BYTE_W)) u_clamp (
        .wrap_i   (wrap_sum[g*BYTE_W +: BYTE_W]),
        .ovf_i    (lane_ovf[g]),
        .sat_i    (in_sat),
        .signed_i (in_signed),
        .sub_i    (in_sub),
        .a_neg_i  (lane_neg[g]),
        .is_top_i (last_b[g]),
        .byte_o   (clamp_sum[g*BYTE_W +: BYTE_W])
      );
    end
  endgenerate

  // single output stage with pass-through ready
  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= '0;
    end else if (in_fire) begin
      out_valid <= 1'b1;
      out_data  <= clamp_sum;
      out_ovf   <= lane_ovf;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // ---------------- assertions ----------------
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ovf))
    else $error("stalled result changed");

  p_byte1_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && !in_sat && !in_sub && mode == LM_B8
    |=> out_data[2*BYTE_W-1:BYTE_W] == $past(in_a[2*BYTE_W-1:BYTE_W] + in_b[2*BYTE_W-1:BYTE_W]))
    else $error("carry leaked into byte 1");

  p_byte0_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && !in_sat && in_sub && mode == LM_B8
    |=> out_data[BYTE_W-1:0] == $past(in_a[BYTE_W-1:0] - in_b[BYTE_W-1:0]))
    else $error("byte 0 did not wrap");

  p_sadd_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_sat && in_signed && !in_sub && mode == LM_B8
    && !in_a[BYTE_W-1] && !in_b[BYTE_W-1]
    && ({1'b0, in_a[BYTE_W-1:0]} + {1'b0, in_b[BYTE_W-1:0]} > {2'b00, {(BYTE_W-1){1'b1}}})
    |=> out_data[BYTE_W-1:0] == {1'b0, {(BYTE_W-1){1'b1}}} && out_ovf[0])
    else $error("signed add did not clamp to max");

  p_usub_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_sat && !in_signed && in_sub && mode == LM_B8
    && (in_a[BYTE_W-1:0] < in_b[BYTE_W-1:0])
    |=> out_data[BYTE_W-1:0] == '0 && out_ovf[0])
    else $error("unsigned subtract did not clamp to zero");

endmodule

// File: tb/test_simd_sat_adder.sv
module test_simd_sat_adder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0, in_b = '0;
  logic [1:0]  in_mode = 2'd0;
  logic        in_sub = 1'b0, in_signed = 1'b0, in_sat = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [7:0]  out_ovf;

  int checks = 0;
  int fails  = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;

  logic [71:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  simd_sat_adder i_simd_sat_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_mode(in_mode), .in_sub(in_sub),
    .in_signed(in_signed), .in_sat(in_sat), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_ovf(out_ovf)
  );

  // arithmetic reference: {ovf[7:0], result[63:0]}
  function automatic logic [71:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] mode, input logic sub,
                                        input logic sgn, input logic sat);
    int w, nl, bpl;
    logic [63:0] res;
    logic [7:0]  ov;
    w   = (mode == 2'd0) ? 8 : (mode == 2'd1) ? 16 : 32;
    nl  = 64 / w;
    bpl = w / 8;
    res = '0;
    ov  = '0;
    for (int k = 0; k < nl; k++) begin
      longint lim, ua, ub, sa, sb, r, val;
      logic o;
      lim = longint'(1) << w;
      ua  = longint'(a >> (k * w)) & (lim - 1);
      ub  = longint'(b >> (k * w)) & (lim - 1);
      if (sgn) begin
        sa  = (ua >= lim / 2) ? ua - lim : ua;
        sb  = (ub >= lim / 2) ? ub - lim : ub;
        r   = sub ? sa - sb : sa + sb;
        o   = (r > lim / 2 - 1) || (r < -(lim / 2));
        val = (o && sat) ? ((r > 0) ? lim / 2 - 1 : -(lim / 2)) : r;
      end else begin
        r   = sub ? ua - ub : ua + ub;
        o   = sub ? (ua < ub) : (r >= lim);
        val = (o && sat) ? (sub ? longint'(0) : lim - 1) : r;
      end
      val = val & (lim - 1);
      res = res | (64'(val) << (k * w));
      for (int j = 0; j < bpl; j++) ov[k * bpl + j] = o;
    end
    return {ov, res};
  endfunction

  task automatic send(input logic [63:0] a, input logic [63:0] b, input logic [1:0] mode,
                      input logic sub, input logic sgn, input logic sat, input string tag);
    bit rdy;
    @(negedge clk);
    in_a = a; in_b = b; in_mode = mode; in_sub = sub; in_signed = sgn; in_sat = sat;
    in_valid = 1'b1;
    forever begin
      rdy = in_ready;
      @(posedge clk);
      if (rdy) begin
        exp_q.push_back(model(a, b, mode, sub, sgn, sat));
        tag_q.push_back(tag);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // consumer back-pressure, changed away from the sampling point
  initial begin
    forever begin
      @(posedge clk);
      #2;
      out_ready = stall_en ? 1'($urandom % 2) : 1'b1;
    end
  end

  // output monitor: a transfer happens at the next edge when valid && ready
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        logic [71:0] e;
        string t;
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R10 unexpected beat: got %h/%h expected none", out_ovf, out_data);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({out_ovf, out_data} !== e) begin
            fails++;
            $display("FAIL %s: got ovf=%h data=%h expected ovf=%h data=%h",
                     t, out_ovf, out_data, e[71:64], e[63:0]);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset values
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0 || out_ovf !== '0) begin
      fails++;
      $display("FAIL R11: got v=%b d=%h o=%h expected 0/0/0", out_valid, out_data, out_ovf);
    end
    rst_n = 1'b1;

    // directed corners
    send(64'h00000000_7FFFFFFF, 64'h00000000_00000001, 2'd3, 1'b0, 1'b1, 1'b1, "R1");
    send(64'h00FF00FF_00FF00FF, 64'h00010001_00010001, 2'd1, 1'b0, 1'b0, 1'b0, "R2");
    send(64'hFFFFFFFF_FFFFFFFF, 64'h01010101_01010101, 2'd0, 1'b0, 1'b0, 1'b0, "R2");
    send(64'h10203040_50607080, 64'h01020304_05060708, 2'd2, 1'b1, 1'b0, 1'b0, "R3");
    send(64'h7F807F80_7F807F80, 64'h01FF01FF_FF01FF01, 2'd0, 1'b0, 1'b1, 1'b0, "R4");
    send(64'h7F807F80_7F807F80, 64'hFF01FF01_01FF01FF, 2'd0, 1'b1, 1'b1, 1'b0, "R4");
    send(64'hFF00FF00_00FF00FF, 64'h01000100_01000100, 2'd0, 1'b1, 1'b0, 1'b0, "R5");
    send(64'hFFFF0001_7FFF8000, 64'h00010001_00010001, 2'd1, 1'b0, 1'b1, 1'b0, "R6");
    send(64'h7FFF0000_80000000, 64'h00010000_00000001, 2'd1, 1'b1, 1'b1, 1'b1, "R7");
    send(64'h00000000_FFFFFFFF, 64'h00000001_00000001, 2'd2, 1'b1, 1'b0, 1'b1, "R8");

    // near-exhaustive 8-bit sweep: every a/b pair, all control combos
    for (int c = 0; c < 8; c++) begin
      logic sub, sgn, sat;
      string tg;
      sub = c[0]; sgn = c[1]; sat = c[2];
      tg = !sat ? "R9" : (sgn ? "R7" : "R8");
      for (int ai = 0; ai < 256; ai++) begin
        for (int j = 0; j < 32; j++) begin
          logic [63:0] a, b;
          for (int k = 0; k < 8; k++) begin
            a[k*8 +: 8] = 8'(ai);
            b[k*8 +: 8] = 8'(j * 8 + k);
          end
          send(a, b, 2'd0, sub, sgn, sat, tg);
        end
      end
    end

    // wider elements with mixed and corner values (R1, R4, R5)
    for (int m = 1; m < 4; m++) begin
      for (int c = 0; c < 8; c++) begin
        for (int n = 0; n < 300; n++) begin
          logic [63:0] a, b;
          a = {$urandom, $urandom};
          b = {$urandom, $urandom};
          if (n % 4 == 0) a = a | 64'h7FFF7FFF_7FFF7FFF;
          if (n % 4 == 1) b = b & 64'h80008000_80008000;
          send(a, b, 2'(m), c[0], c[1], c[2], (m == 3) ? "R1" : (c[1] ? "R4" : "R5"));
        end
      end
    end

    // random back-pressure: R10
    stall_en = 1'b1;
    for (int n = 0; n < 3000; n++) begin
      send({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom % 4),
           1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), "R10");
    end
    go_idle();
    stall_en = 1'b0;

    repeat (200) begin
      if (exp_q.size() == 0) break;
      @(posedge clk);
    end
    repeat (4) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10: got %0d beats outstanding expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule